// File: doc/BRIEF.md
# Status-Coded I2C Master Transmitter

This block is a byte-level I2C master transmit engine that a host processor steers one bus event at a time. The host writes a control word holding a start request, a stop request and the interrupt flag (SI), and an 8-bit byte holding either the address or the data to send. Each time a bus event finishes, the engine posts a fixed 8-bit status code, sets SI and parks the bus with SCL held low. The host reads the code, loads the next byte if one is needed, and then clears SI. The start/stop request bits written in that same clearing write choose what the engine does next.

The engine can send a START, a repeated START, a STOP, or a STOP followed at once by a new START. It sends the address byte (MSB first, read/write flag in bit 0) and data bytes, samples the acknowledge bit, and watches for loss of arbitration against another master. SCL and SDA are open-drain: an output of 1 pulls the line low. SCL timing comes from a divider input. One quarter of an SCL period lasts `clkDiv+1` clock cycles, and `clkDiv` must be at least 2. When an address with the read flag set is acknowledged, the engine only reports the read-direction code. Receiving data is not part of this block.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset the status is F8h, SI is 0 and neither line is pulled low. F8h is the only status reported with SI clear. Every status code has bits [2:0] equal to 0.
- R2: A control write with the start bit set, while idle and with the bus free, sends a START: SDA falls while SCL is high. The status then becomes 08h with SI set, and the start bit reads back 0.
- R3: After an address byte with bit 0 = 0 is sent MSB first, the status is 18h if the receiver pulled SDA low on the ninth clock and 20h if it did not.
- R4: Clearing SI with start=0 and stop=0 after a transfer sends the data register byte MSB first. The status is then 28h on acknowledge and 30h on no acknowledge.
- R5: Clearing SI with start=1 and stop=0 after a transfer sends a repeated START and reports 10h.
- R6: Clearing SI with stop=1 and start=0 sends a STOP (SDA rises while SCL is high). Afterwards the status is F8h, SI is 0, both lines are released and the stop bit reads back 0.
- R7: Clearing SI with both start=1 and stop=1 sends a STOP and then a new START with no idle gap, ending at status 08h with the stop bit cleared.
- R8: If SDA reads low on the bus while the engine is releasing it for a 1 bit of an address or data byte, the engine releases both lines and reports 38h with SI set.
- R9: Clearing SI in state 38h with start=1 holds the engine idle (F8h, lines released, start bit still 1) until a STOP is seen on the bus, and then sends a START and reports 08h. With start=0, the engine goes to F8h and sends nothing.
- R10: While SI is set in any state other than 38h, SCL is held low. Writes to the data register are ignored while SI is 0.
- R11: After an address byte with bit 0 = 1, the status is 40h on acknowledge and 48h on no acknowledge.
- R12: During a byte, SCL rises once every 4*(clkDiv+1) cycles, and SDA driven by the engine changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkDiv | input | DIV_W | Quarter-SCL-period length minus one, in clock cycles |
| hostWr | input | 1 | Control write strobe |
| hostStart | input | 1 | Start request bit written by the control write |
| hostStop | input | 1 | Stop request bit written by the control write |
| hostSi | input | 1 | SI value written; 0 clears SI, 1 has no effect |
| dataWr | input | 1 | Data register write strobe |
| dataIn | input | 8 | Byte to load into the data register |
| statusOut | output | 8 | Current status code |
| siOut | output | 1 | Interrupt flag |
| startFlag | output | 1 | Start request bit readback |
| stopFlag | output | 1 | Stop request bit readback |
| dataOut | output | 8 | Data register readback |
| sclIn | input | 1 | Sensed SCL level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaIn | input | 1 | Sensed SDA level |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The transmit path is run with an address byte that has the write flag clear, an address with the read flag set, and data bytes with mixed bit patterns. Each is run once with the receiver acknowledging and once without, so every one of the six post-byte codes must appear and the codes cannot be confused with each other. The next-action choices are each taken from a post-transfer state: data, repeated START, STOP, and STOP followed by START. A bus-event scoreboard checks that exactly the expected STARTs, STOPs and bytes appear on the wires. A second master forces SDA low in the middle of a 0xFF byte, once with a queued restart and once without, to tell apart a START that waits for a free bus from a plain drop to idle.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BYTE,
    S_HOLD,
    S_STOP,
    S_LOST
  } txState_t;

  typedef struct packed {
    logic runDiv;     // divider counts while a timed bus phase runs
    logic loadShift;  // copy data register into shifter
    logic shiftNext;  // advance shifter by one bit
    logic dataWrOk;   // host may write the data register
  } dpCtl_t;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_D_ACK   = 8'h28;
  localparam logic [7:0] ST_D_NACK  = 8'h30;
  localparam logic [7:0] ST_LOST    = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

endpackage

// File: rtl/i2c_tx_datapath.sv
module i2c_tx_datapath
  import i2c_tx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clkDiv,
  input  dpCtl_t            ctl,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              tick,
  output logic              txBit,
  output logic              sdaSync,
  output logic              busBusy,
  output logic [BYTE_W-1:0] dataReg
);

  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [SYNC_N-1:0] sclPipe;
  logic [SYNC_N-1:0] sdaPipe;
  logic              sclSync;
  logic              sdaPrev;

  // quarter-period timebase
  assign tick = ctl.runDiv && (divCnt == clkDiv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    divCnt <= '0;
    else if (!ctl.runDiv || tick)  divCnt <= '0;
    else                           divCnt <= divCnt + 1'b1;
  end

  // host byte and transmit shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (dataWr && ctl.dataWrOk) dataReg <= dataIn;
      if (ctl.loadShift)          shiftReg <= dataReg;
      else if (ctl.shiftNext)     shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
    end
  end

  assign txBit = shiftReg[BYTE_W-1];

  // line synchronisers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_N-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_N-2:0], sdaIn};
    end
  end

  assign sclSync = sclPipe[SYNC_N-1];
  assign sdaSync = sdaPipe[SYNC_N-1];

  // bus occupancy: set by any START, cleared by any STOP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdaPrev <= 1'b1;
      busBusy <= 1'b0;
    end else begin
      sdaPrev <= sdaSync;
      if (sclSync && sdaPrev && !sdaSync)      busBusy <= 1'b1;
      else if (sclSync && !sdaPrev && sdaSync) busBusy <= 1'b0;
    end
  end

  // R10: data register frozen while host access is closed
  p_data_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.dataWrOk |=> $stable(dataReg));

endmodule

// File: rtl/i2c_tx_ctrl.sv
module i2c_tx_ctrl
  import i2c_tx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       txBit,
  input  logic       sdaSync,
  input  logic       busBusy,
  input  logic       addrRead,
  input  logic       hostWr,
  input  logic       hostStart,
  input  logic       hostStop,
  input  logic       hostSi,
  output dpCtl_t     ctl,
  output logic [7:0] statusOut,
  output logic       siOut,
  output logic       startFlag,
  output logic       stopFlag,
  output logic       sclLow,
  output logic       sdaLow
);

  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

  txState_t         st;
  logic [2:0]       q;
  logic [IDX_W-1:0] bitIdx;
  logic             rep;
  logic             isAddr;
  logic             ackSeen;
  logic             siClear;

  function automatic logic [7:0] byteCode(input logic addr, input logic rd,
                                          input logic ack);
    if (addr && rd)  return ack ? ST_AR_ACK : ST_AR_NACK;
    else if (addr)   return ack ? ST_AW_ACK : ST_AW_NACK;
    else             return ack ? ST_D_ACK  : ST_D_NACK;
  endfunction

  assign siClear       = hostWr && !hostSi && siOut;
  assign ctl.runDiv    = (st == S_START) || (st == S_BYTE) || (st == S_STOP);
  assign ctl.loadShift = (st == S_HOLD) && siClear && !hostStop && !hostStart;
  assign ctl.shiftNext = (st == S_BYTE) && tick && (q == 3'd3) && (bitIdx != ACK_IDX);
  assign ctl.dataWrOk  = siOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      q         <= '0;
      bitIdx    <= '0;
      rep       <= 1'b0;
      isAddr    <= 1'b0;
      ackSeen   <= 1'b0;
      statusOut <= ST_IDLE;
      siOut     <= 1'b0;
      startFlag <= 1'b0;
      stopFlag  <= 1'b0;
      sclLow    <= 1'b0;
      sdaLow    <= 1'b0;
    end else begin
      if (hostWr) begin
        startFlag <= hostStart;
        stopFlag  <= hostStop;
        if (!hostSi) siOut <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          if (startFlag && !busBusy) begin
            st        <= S_START;
            q         <= '0;
            rep       <= 1'b0;
            startFlag <= 1'b0;
          end
        end
        // q0: lines settle (SCL still low on a repeat), q1-q2: setup, q3-q4: hold
        S_START: begin
          if (tick) begin
            q <= q + 3'd1;
            case (q)
              3'd0: sclLow <= 1'b0;
              3'd2: sdaLow <= 1'b1;
              3'd4: begin
                sclLow    <= 1'b1;
                st        <= S_HOLD;
                siOut     <= 1'b1;
                isAddr    <= 1'b1;
                statusOut <= rep ? ST_RSTART : ST_START;
              end
              default: ;
            endcase
          end
        end
        // q0: SCL low, new SDA at its end; q1 end: SCL up; q2 end: sample; q3 end: SCL down
        S_BYTE: begin
          if (tick) begin
            q <= q + 3'd1;
            case (q)
              3'd0: sdaLow <= (bitIdx != ACK_IDX) && !txBit;
              3'd1: sclLow <= 1'b0;
              3'd2: begin
                if (bitIdx == ACK_IDX) ackSeen <= !sdaSync;
                else if (!sdaLow && !sdaSync) begin
                  st        <= S_LOST;
                  sclLow    <= 1'b0;
                  sdaLow    <= 1'b0;
                  siOut     <= 1'b1;
                  isAddr    <= 1'b0;
                  statusOut <= ST_LOST;
                end
              end
              default: begin
                q      <= '0;
                sclLow <= 1'b1;
                if (bitIdx == ACK_IDX) begin
                  st        <= S_HOLD;
                  siOut     <= 1'b1;
                  isAddr    <= 1'b0;
                  statusOut <= byteCode(isAddr, addrRead, ackSeen);
                end else begin
                  bitIdx <= bitIdx + 1'b1;
                end
              end
            endcase
          end
        end
        S_HOLD: begin
          if (siClear) begin
            q <= '0;
            if (hostStop) begin
              st     <= S_STOP;
              sdaLow <= 1'b1;
            end else if (hostStart) begin
              st        <= S_START;
              rep       <= 1'b1;
              sdaLow    <= 1'b0;
              startFlag <= 1'b0;
            end else begin
              st     <= S_BYTE;
              bitIdx <= '0;
            end
          end
        end
        // q0 end: SCL up; q1-q2: setup; q2 end: SDA up; q3: bus free time
        S_STOP: begin
          if (tick) begin
            q <= q + 3'd1;
            case (q)
              3'd0: sclLow <= 1'b0;
              3'd2: sdaLow <= 1'b0;
              3'd3: begin
                q        <= '0;
                stopFlag <= 1'b0;
                if (startFlag) begin
                  st        <= S_START;
                  rep       <= 1'b0;
                  startFlag <= 1'b0;
                end else begin
                  st        <= S_IDLE;
                  statusOut <= ST_IDLE;
                end
              end
              default: ;
            endcase
          end
        end
        S_LOST: begin
          if (siClear) begin
            st        <= S_IDLE;
            statusOut <= ST_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: the no-information code never carries the flag; flagged codes are aligned
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (statusOut == ST_IDLE) |-> !siOut);
  p_code_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    siOut |-> (statusOut != ST_IDLE) && (statusOut[2:0] == 3'b000));
  // R10: bus parked with SCL low while host owns the next step
  p_hold_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (siOut && statusOut != ST_LOST) |-> sclLow);
  // R8: lost arbitration leaves both lines free
  p_lost_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (statusOut == ST_LOST) |-> (!sclLow && !sdaLow));
  // R12: data bit changes only with SCL pulled low
  p_sda_moves_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st) == S_BYTE && !$stable(sdaLow)) |-> sclLow);
  // R6: finished STOP leaves the stop request cleared
  p_stop_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_STOP && st == S_IDLE && !$past(hostWr)) |-> !stopFlag);

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
  import i2c_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             hostWr,
  input  logic             hostStart,
  input  logic             hostStop,
  input  logic             hostSi,
  input  logic             dataWr,
  input  logic [7:0]       dataIn,
  output logic [7:0]       statusOut,
  output logic             siOut,
  output logic             startFlag,
  output logic             stopFlag,
  output logic [7:0]       dataOut,
  input  logic             sclIn,
  output logic             sclOe,
  input  logic             sdaIn,
  output logic             sdaOe
);

  localparam int BYTE_W = 8;

  dpCtl_t ctl;
  logic   tick;
  logic   txBit;
  logic   sdaSync;
  logic   busBusy;

  i2c_tx_datapath #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .SYNC_N(2)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clkDiv  (clkDiv),
    .ctl     (ctl),
    .dataWr  (dataWr),
    .dataIn  (dataIn),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .tick    (tick),
    .txBit   (txBit),
    .sdaSync (sdaSync),
    .busBusy (busBusy),
    .dataReg (dataOut)
  );

  i2c_tx_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .txBit     (txBit),
    .sdaSync   (sdaSync),
    .busBusy   (busBusy),
    .addrRead  (dataOut[0]),
    .hostWr    (hostWr),
    .hostStart (hostStart),
    .hostStop  (hostStop),
    .hostSi    (hostSi),
    .ctl       (ctl),
    .statusOut (statusOut),
    .siOut     (siOut),
    .startFlag (startFlag),
    .stopFlag  (stopFlag),
    .sclLow    (sclOe),
    .sdaLow    (sdaOe)
  );

endmodule

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb;

  localparam int EV_START = 256;
  localparam int EV_STOP  = 257;
  localparam int DIV      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostWr = 1'b0, hostStart = 1'b0, hostStop = 1'b0, hostSi = 1'b1;
  logic dataWr = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] statusOut, dataOut;
  logic siOut, startFlag, stopFlag, sclOe, sdaOe;
  logic slaveAck = 1'b0, otherLow = 1'b0, ackEn = 1'b0, lossArm = 1'b0;
  wire  scl = !sclOe;
  wire  sda = !(sdaOe || slaveAck || otherLow);

  int tests = 0, fails = 0, cycles = 0, lastPeriod = 0;
  bit done = 1'b0;
  int expQ[$];

  always #5 clk = ~clk;

  i2c_tx_master #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .clkDiv(8'(DIV)),
    .hostWr(hostWr), .hostStart(hostStart), .hostStop(hostStop), .hostSi(hostSi),
    .dataWr(dataWr), .dataIn(dataIn),
    .statusOut(statusOut), .siOut(siOut), .startFlag(startFlag), .stopFlag(stopFlag),
    .dataOut(dataOut), .sclIn(scl), .sclOe(sclOe), .sdaIn(sda), .sdaOe(sdaOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: decodes the wires, acts as receiver and rival master, scores events
  logic pScl = 1'b1, pSda = 1'b1;
  int bitCnt = 0, riseCyc = 0;
  logic [7:0] shiftIn = '0;

  task automatic scoreEvent(input int ev);
    string req;
    int exp;
    req = (ev == EV_START) ? "R2 start event" : (ev == EV_STOP) ? "R6 stop event" : "R3 byte event";
    if (expQ.size() == 0) check(1'b0, req, ev, -1);
    else begin
      exp = expQ.pop_front();
      check(ev == exp, req, ev, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (pScl && scl && pSda && !sda) begin
        scoreEvent(EV_START);
        bitCnt = 0;
      end else if (pScl && scl && !pSda && sda) begin
        scoreEvent(EV_STOP);
        bitCnt = 0;
      end else if (!pScl && scl) begin
        if (bitCnt == 1) riseCyc = cycles;
        if (bitCnt == 2) lastPeriod = cycles - riseCyc;
        if (bitCnt < 8) begin
          shiftIn = {shiftIn[6:0], sda};
          bitCnt++;
          if (bitCnt == 8) scoreEvent(int'(shiftIn));
        end
      end else if (pScl && !scl) begin
        if (bitCnt == 8) begin
          slaveAck = ackEn;
          bitCnt = 9;
        end else if (bitCnt == 9) begin
          slaveAck = 1'b0;
          bitCnt = 0;
        end else if (lossArm && bitCnt == 2) begin
          otherLow = 1'b1;
          lossArm = 1'b0;
        end
      end
    end
    pScl = scl;
    pSda = sda;
  end

  task automatic hostCtl(input logic s, input logic p, input logic i);
    @(negedge clk);
    hostWr = 1'b1; hostStart = s; hostStop = p; hostSi = i;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic loadData(input logic [7:0] d);
    @(negedge clk);
    dataWr = 1'b1; dataIn = d;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic waitSi();
    int n = 0;
    while (!siOut && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    while (statusOut != 8'hF8 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input logic ack, input logic [7:0] code,
                          input string req);
    loadData(d);
    expQ.push_back(int'(d));
    ackEn = ack;
    hostCtl(1'b0, 1'b0, 1'b0);
    waitSi();
    check(siOut && statusOut == code, req, statusOut, code);
  endtask

  initial begin
    wait (cycles == 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(statusOut == 8'hF8 && !siOut, "R1 reset status", statusOut, 8'hF8);
    check(!sclOe && !sdaOe, "R1 lines released", {sclOe, sdaOe}, 0);
    loadData(8'h5A);
    check(dataOut == 8'h00, "R10 data write ignored without SI", dataOut, 0);

    // START, address write ack, two data bytes
    expQ.push_back(EV_START);
    hostCtl(1'b1, 1'b0, 1'b1);
    waitSi();
    check(statusOut == 8'h08, "R2 start code", statusOut, 8'h08);
    check(!startFlag, "R2 start bit consumed", startFlag, 0);
    repeat (100) @(negedge clk);
    check(sclOe && siOut && statusOut == 8'h08, "R10 SCL stretched", sclOe, 1);
    loadData(8'hA4);
    check(dataOut == 8'hA4, "R10 data write with SI", dataOut, 8'hA4);
    sendByte(8'hA4, 1'b1, 8'h18, "R3 addr write ack");
    sendByte(8'h3C, 1'b1, 8'h28, "R4 data ack");
    check(lastPeriod == 4 * (DIV + 1), "R12 SCL period", lastPeriod, 4 * (DIV + 1));
    sendByte(8'hC3, 1'b0, 8'h30, "R4 data nack");

    // repeated START then nack'd address, STOP
    expQ.push_back(EV_START);
    hostCtl(1'b1, 1'b0, 1'b0);
    waitSi();
    check(statusOut == 8'h10, "R5 repeated start code", statusOut, 8'h10);
    sendByte(8'hA4, 1'b0, 8'h20, "R3 addr write nack");
    expQ.push_back(EV_STOP);
    hostCtl(1'b0, 1'b1, 1'b0);
    waitIdle();
    check(statusOut == 8'hF8 && !siOut, "R6 idle after stop", statusOut, 8'hF8);
    check(!stopFlag && !sclOe && !sdaOe, "R6 stop bit cleared and bus free",
          {stopFlag, sclOe, sdaOe}, 0);

    // read-direction addresses
    expQ.push_back(EV_START);
    hostCtl(1'b1, 1'b0, 1'b1);
    waitSi();
    sendByte(8'hA5, 1'b1, 8'h40, "R11 addr read ack");
    expQ.push_back(EV_START);
    hostCtl(1'b1, 1'b0, 1'b0);
    waitSi();
    check(statusOut == 8'h10, "R5 repeated start after read", statusOut, 8'h10);
    sendByte(8'hA5, 1'b0, 8'h48, "R11 addr read nack");

    // STOP followed by START
    expQ.push_back(EV_STOP);
    expQ.push_back(EV_START);
    hostCtl(1'b1, 1'b1, 1'b0);
    waitSi();
    check(statusOut == 8'h08, "R7 stop then start code", statusOut, 8'h08);
    check(!stopFlag && !startFlag, "R7 request bits cleared", {stopFlag, startFlag}, 0);

    // arbitration loss with a queued restart
    sendByte(8'hA4, 1'b1, 8'h18, "R3 addr before loss");
    loadData(8'hFF);
    lossArm = 1'b1;
    hostCtl(1'b0, 1'b0, 1'b0);
    waitSi();
    check(statusOut == 8'h38, "R8 lost code", statusOut, 8'h38);
    check(!sclOe && !sdaOe, "R8 lines released", {sclOe, sdaOe}, 0);
    hostCtl(1'b1, 1'b0, 1'b0);
    repeat (200) @(negedge clk);
    check(statusOut == 8'hF8 && !siOut && !sclOe && !sdaOe && startFlag,
          "R9 start waits for free bus", statusOut, 8'hF8);
    expQ.push_back(EV_STOP);
    expQ.push_back(EV_START);
    otherLow = 1'b0;
    waitSi();
    check(statusOut == 8'h08, "R9 queued start issued", statusOut, 8'h08);

    // arbitration loss, then drop to idle
    sendByte(8'hA4, 1'b1, 8'h18, "R3 addr before second loss");
    loadData(8'hFF);
    lossArm = 1'b1;
    hostCtl(1'b0, 1'b0, 1'b0);
    waitSi();
    check(statusOut == 8'h38, "R8 second lost code", statusOut, 8'h38);
    hostCtl(1'b0, 1'b0, 1'b0);
    repeat (300) @(negedge clk);
    check(statusOut == 8'hF8 && !siOut && !sclOe && !sdaOe, "R9 idle without restart",
          statusOut, 8'hF8);
    expQ.push_back(EV_STOP);
    otherLow = 1'b0;
    repeat (50) @(negedge clk);
    check(expQ.size() == 0, "R6 all bus events seen", expQ.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule